// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block takes a 32-bit core from the instruction that traps into the first fetch of the handler, and back again. The core raises one request at a time: a fault, with one flag for each fixed-vector cause, or a software interrupt with a number, a break, a stacked return, or a fast return. The block looks up the handler address through a single-outstanding valid/ready memory port. It saves the old status word and the return address on the stack, then writes new PC, PSW and SP values through write-enable strobes in one closing cycle.

A fixed vector that holds zero or the placeholder 0x00020000 is treated as not installed, and the block raises a halt pulse instead of entering the handler. Software interrupt 255 is a system-call exit and never touches memory. A break with a null table base also halts. The stacked return pops PC and then PSW. The fast return copies the backup registers with no stack traffic. Both return kinds trap as privileged instructions when they are issued in user mode.

Top module: `exc_seq`

## Requirements
- R1: Fault flags (bit 0 access, bit 1 undefined, bit 2 privileged, bit 3 floating point) raised together are served in that order, lowest bit first. The vector words are at 0xFFFFFFD4, 0xFFFFFFDC, 0xFFFFFFD0 and 0xFFFFFFE4 respectively.
- R2: A fixed vector that reads 0 or 0x00020000 gives one halt pulse, no PC/PSW/SP write and no stack write.
- R3: Entry writes the old PSW at SP-4, then the return PC at SP-8, and sets SP to SP-8.
- R4: Entry loads PC with the handler word and writes PSW with bits 16 (interrupt enable), 17 (stack select) and 20 (user mode) cleared. All other bits keep their old values.
- R5: Software interrupt n (0 to 254) reads its handler at table base + 4*n. A break reads it at the table base itself.
- R6: A break with table base zero gives a halt pulse and makes no memory access and no register write.
- R7: Software interrupt 255 gives one syscall pulse, with no memory access and no register write.
- R8: A stacked return in supervisor mode reads PC at SP and PSW at SP+4, then sets SP to SP+8. If the restored bit 20 is set, bit 17 is forced to 1.
- R9: A stacked or fast return issued with PSW bit 20 set performs a privileged-instruction entry, with the request PC as the return PC.
- R10: A fast return in supervisor mode writes PSW from the backup PSW and PC from the backup PC. It makes no memory access and does not write SP.
- R11: req_ready is high only while the block is idle. busy is high from acceptance through the closing register-write cycle. A memory request holds its address and direction until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_kind | input | 3 | 0 fault, 1 software interrupt, 2 break, 3 stacked return, 4 fast return |
| req_fault | input | 4 | Fault cause flags, one per fixed vector |
| req_intno | input | 8 | Software interrupt number |
| req_pc | input | 32 | Return PC for entries, trapping PC for returns |
| psw_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| intb_in | input | 32 | Interrupt table base |
| bpsw_in | input | 32 | Backup status word |
| bpc_in | input | 32 | Backup PC |
| busy | output | 1 | Sequence in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 32 | New PC |
| psw_we | output | 1 | PSW write strobe |
| psw_wdata | output | 32 | New PSW |
| sp_we | output | 1 | SP write strobe |
| sp_wdata | output | 32 | New SP |
| halt | output | 1 | Unhandled-exception halt pulse |
| syscall | output | 1 | System-call exit pulse |

## Verification
The bench raises every combination of the four fault flags at once. A wrong priority order would vector to the wrong word. Each fixed vector is then loaded with zero and with the placeholder. A block that missed either value would jump to address zero or into reserved space and would push a frame it should not. All 255 vectorable interrupt numbers are swept against a table whose entries encode their own address, which exposes an offset or scaling slip. Number 255, a null-base break, and returns in both privilege modes check that the system-call path, the halt path, the forced stack-select bit and the privilege trap each stay off memory, or on it, as the requirements state.

// File: rtl/exc_seq_pkg.sv
// Package: shared request kinds, sequencer states and fixed-vector lookup.
// Assumes fault index 0..3 maps to access, undefined, privileged, floating point.
package exc_seq_pkg;

    typedef enum logic [2:0] {
        K_FAULT = 3'd0,
        K_SWI   = 3'd1,
        K_BRK   = 3'd2,
        K_RTE   = 3'd3,
        K_RTFI  = 3'd4
    } kind_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VEC,
        S_PUSH_PSW,
        S_PUSH_PC,
        S_ENTRY_DONE,
        S_POP_PC,
        S_POP_PSW,
        S_RET_DONE,
        S_FAST_DONE
    } state_t;

    localparam logic [1:0] IDX_PRIV = 2'd2;

    // Fixed vector word address for a fault index.
    function automatic logic [31:0] fixed_vec(input logic [1:0] idx);
        case (idx)
            2'd0:    fixed_vec = 32'hFFFF_FFD4;
            2'd1:    fixed_vec = 32'hFFFF_FFDC;
            2'd2:    fixed_vec = 32'hFFFF_FFD0;
            default: fixed_vec = 32'hFFFF_FFE4;
        endcase
    endfunction

endpackage

// File: rtl/exc_seq_prio.sv
// Fixed-priority picker for simultaneous fault flags.
// Lowest set bit wins; valid is low when no flag is set.
module exc_seq_prio #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  flags,
    output logic [IW-1:0] idx,
    output logic          valid
);
    logic [N-1:0] sel;

    // Pick the lowest set flag and report its index.
    always_comb begin
        sel   = '0;
        idx   = '0;
        valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags[i]) begin
                sel      = '0;
                sel[i]   = 1'b1;
                idx      = IW'(i);
                valid    = 1'b1;
            end
        end
    end

    // R1
    prio_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel) && (valid == (flags != '0)));

    // R1
    prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0]) |-> (idx == '0));

endmodule

// File: rtl/exc_seq_pswfix.sv
// Status-word shaping for entry and for stacked return.
// Entry clears the three masked bits; return forces stack-select when user mode is set.
module exc_seq_pswfix #(
    parameter int DW   = 32,
    parameter int I_B  = 16,
    parameter int U_B  = 17,
    parameter int PM_B = 20
) (
    input  logic [DW-1:0] psw_old,
    input  logic [DW-1:0] psw_pop,
    output logic [DW-1:0] psw_entry,
    output logic [DW-1:0] psw_ret
);
    // Per-bit entry mask: the three control bits go to zero.
    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b == I_B || b == U_B || b == PM_B) begin : g_clr
            assign psw_entry[b] = 1'b0;
        end else begin : g_keep
            assign psw_entry[b] = psw_old[b];
        end
    end

    // Popped word with stack-select forced in user mode.
    always_comb begin
        psw_ret = psw_pop;
        if (psw_pop[PM_B]) psw_ret[U_B] = 1'b1;
    end
endmodule

// File: rtl/exc_seq.sv
// Exception entry and return sequencer (top).
// Assumes: one request at a time, memory read data valid in the ready cycle,
// register strobes are consumed by the core in the cycle they are high.
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter int DW          = 32,
    parameter int NFAULT      = 4,
    parameter int INW         = 8,
    parameter int SYSCALL_NO  = 255,
    parameter logic [31:0] VEC_RESERVED = 32'h0002_0000,
    parameter int I_B         = 16,
    parameter int U_B         = 17,
    parameter int PM_B        = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [NFAULT-1:0] req_fault,
    input  logic [INW-1:0]    req_intno,
    input  logic [DW-1:0]     req_pc,
    input  logic [DW-1:0]     psw_in,
    input  logic [DW-1:0]     sp_in,
    input  logic [DW-1:0]     intb_in,
    input  logic [DW-1:0]     bpsw_in,
    input  logic [DW-1:0]     bpc_in,
    output logic              busy,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ready,
    input  logic [DW-1:0]     mem_rdata,
    output logic              pc_we,
    output logic [DW-1:0]     pc_wdata,
    output logic              psw_we,
    output logic [DW-1:0]     psw_wdata,
    output logic              sp_we,
    output logic [DW-1:0]     sp_wdata,
    output logic              halt,
    output logic              syscall
);
    localparam int FIW = $clog2(NFAULT);
    localparam logic [DW-1:0] WORD = DW'(4);

    state_t          st;
    logic [DW-1:0]   r_psw, r_sp, r_rpc, r_vaddr, r_handler, r_npc, r_npsw;
    logic            r_chk, halt_q, sys_q;
    logic [FIW-1:0]  p_idx;
    logic            p_valid;
    logic [DW-1:0]   psw_entry, psw_ret, swi_off;
    kind_t           kind;
    logic            accept, mem_fire, vec_empty;

    exc_seq_prio #(.N(NFAULT)) u_prio (
        .clk(clk), .rst_n(rst_n), .flags(req_fault), .idx(p_idx), .valid(p_valid)
    );

    exc_seq_pswfix #(.DW(DW), .I_B(I_B), .U_B(U_B), .PM_B(PM_B)) u_psw (
        .psw_old(r_psw), .psw_pop(r_npsw), .psw_entry(psw_entry), .psw_ret(psw_ret)
    );

    assign kind      = kind_t'(req_kind);
    assign req_ready = (st == S_IDLE);
    assign busy      = (st != S_IDLE);
    assign accept    = req_valid && req_ready;
    assign mem_fire  = mem_valid && mem_ready;
    assign swi_off   = {{(DW-INW-2){1'b0}}, req_intno, 2'b00};
    assign vec_empty = (mem_rdata == '0) || (mem_rdata == VEC_RESERVED);
    assign halt      = halt_q;
    assign syscall   = sys_q;

    // Memory request and register strobes decoded from the current state.
    always_comb begin
        mem_valid = 1'b0; mem_write = 1'b0; mem_addr = '0; mem_wdata = '0;
        pc_we = 1'b0; psw_we = 1'b0; sp_we = 1'b0;
        pc_wdata = '0; psw_wdata = '0; sp_wdata = '0;
        case (st)
            S_VEC:      begin mem_valid = 1'b1; mem_addr = r_vaddr; end
            S_PUSH_PSW: begin mem_valid = 1'b1; mem_write = 1'b1;
                              mem_addr = r_sp - WORD; mem_wdata = r_psw; end
            S_PUSH_PC:  begin mem_valid = 1'b1; mem_write = 1'b1;
                              mem_addr = r_sp - 2 * WORD; mem_wdata = r_rpc; end
            S_POP_PC:   begin mem_valid = 1'b1; mem_addr = r_sp; end
            S_POP_PSW:  begin mem_valid = 1'b1; mem_addr = r_sp + WORD; end
            S_ENTRY_DONE: begin
                pc_we = 1'b1; pc_wdata = r_handler;
                psw_we = 1'b1; psw_wdata = psw_entry;
                sp_we = 1'b1; sp_wdata = r_sp - 2 * WORD;
            end
            S_RET_DONE: begin
                pc_we = 1'b1; pc_wdata = r_npc;
                psw_we = 1'b1; psw_wdata = psw_ret;
                sp_we = 1'b1; sp_wdata = r_sp + 2 * WORD;
            end
            S_FAST_DONE: begin
                pc_we = 1'b1; pc_wdata = r_npc;
                psw_we = 1'b1; psw_wdata = r_npsw;
            end
            default: ;
        endcase
    end

    // Sequencer state, captured context and one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
            r_psw <= '0; r_sp <= '0; r_rpc <= '0; r_vaddr <= '0;
            r_handler <= '0; r_npc <= '0; r_npsw <= '0;
            r_chk <= 1'b0; halt_q <= 1'b0; sys_q <= 1'b0;
        end else begin
            halt_q <= 1'b0;
            sys_q  <= 1'b0;
            case (st)
                S_IDLE: if (accept) begin
                    r_psw <= psw_in;
                    r_sp  <= sp_in;
                    r_rpc <= req_pc;
                    r_chk <= 1'b1;
                    case (kind)
                        K_FAULT: if (p_valid) begin
                            r_vaddr <= fixed_vec(p_idx);
                            st      <= S_VEC;
                        end
                        K_SWI: if (req_intno == INW'(SYSCALL_NO)) begin
                            sys_q <= 1'b1;
                        end else begin
                            r_vaddr <= intb_in + swi_off;
                            r_chk   <= 1'b0;
                            st      <= S_VEC;
                        end
                        K_BRK: if (intb_in == '0) begin
                            halt_q <= 1'b1;
                        end else begin
                            r_vaddr <= intb_in;
                            r_chk   <= 1'b0;
                            st      <= S_VEC;
                        end
                        K_RTE, K_RTFI: if (psw_in[PM_B]) begin
                            r_vaddr <= fixed_vec(IDX_PRIV);
                            st      <= S_VEC;
                        end else if (kind == K_RTE) begin
                            st <= S_POP_PC;
                        end else begin
                            r_npc  <= bpc_in;
                            r_npsw <= bpsw_in;
                            st     <= S_FAST_DONE;
                        end
                        default: ;
                    endcase
                end
                S_VEC: if (mem_fire) begin
                    if (r_chk && vec_empty) begin
                        halt_q <= 1'b1;
                        st     <= S_IDLE;
                    end else begin
                        r_handler <= mem_rdata;
                        st        <= S_PUSH_PSW;
                    end
                end
                S_PUSH_PSW: if (mem_fire) st <= S_PUSH_PC;
                S_PUSH_PC:  if (mem_fire) st <= S_ENTRY_DONE;
                S_POP_PC:   if (mem_fire) begin r_npc  <= mem_rdata; st <= S_POP_PSW; end
                S_POP_PSW:  if (mem_fire) begin r_npsw <= mem_rdata; st <= S_RET_DONE; end
                default:    st <= S_IDLE;
            endcase
        end
    end

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    // R11
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!busy && !pc_we && !mem_valid));

    // R2
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!pc_we && !psw_we && !sp_we && !mem_valid));

    // R7
    syscall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syscall |-> (!mem_valid && !pc_we && !busy));

    // R4
    entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && sp_we && (sp_wdata == r_sp - 2 * WORD)) |->
        (!psw_wdata[I_B] && !psw_wdata[U_B] && !psw_wdata[PM_B]));

    // R8
    ret_ustack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && (sp_wdata == r_sp + 2 * WORD) && psw_wdata[PM_B]) |-> psw_wdata[U_B]);

endmodule

// File: tb/test_exc_seq.sv
module test_exc_seq;
    localparam logic [31:0] MASK = 32'h0013_0000;
    localparam logic [31:0] TBL  = 32'h0000_4000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_kind = '0;
    logic [3:0] req_fault = '0;
    logic [7:0] req_intno = '0;
    logic [31:0] req_pc = '0, psw_in = '0, sp_in = '0, intb_in = '0, bpsw_in = '0, bpc_in = '0;
    logic busy, mem_valid, mem_write, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic pc_we, psw_we, sp_we, halt, syscall;
    logic [31:0] pc_wdata, psw_wdata, sp_wdata;

    exc_seq i_exc_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_fault(req_fault), .req_intno(req_intno), .req_pc(req_pc),
        .psw_in(psw_in), .sp_in(sp_in), .intb_in(intb_in), .bpsw_in(bpsw_in), .bpc_in(bpc_in),
        .busy(busy), .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .psw_we(psw_we), .psw_wdata(psw_wdata),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .halt(halt), .syscall(syscall)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0, lat = 0, lcnt = 0;
    logic [31:0] stk [64];
    logic [31:0] v_acc, v_und, v_prv, v_fp;
    bit s_pc, s_psw, s_sp, s_halt, s_sys, s_busy_rdy;
    logic [31:0] g_pc, g_psw, g_sp;
    int w_cnt, r_cnt;
    logic [31:0] w_addr [4], w_data [4], r_addr [4];

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (a[31:8] == 24'hFFFFFF) begin
            case (a[7:0])
                8'hD0:   return v_prv;
                8'hD4:   return v_acc;
                8'hDC:   return v_und;
                8'hE4:   return v_fp;
                default: return 32'h0;
            endcase
        end else if (a[31:12] == 20'h4) return 32'h8000_0000 ^ a;
        else return stk[a[7:2]];
    endfunction

    // Memory model: answers after lat cycles, drives just after the clock edge.
    always @(posedge clk) begin
        #1;
        if (mem_ready) mem_ready = 1'b0;
        else if (mem_valid) begin
            if (lcnt >= lat) begin
                mem_ready = 1'b1;
                mem_rdata = rd(mem_addr);
                lcnt = 0;
            end else lcnt++;
        end
    end

    // Monitor: records strobes and memory transfers at the falling edge.
    always @(negedge clk) begin
        cycles++;
        if (pc_we)  begin s_pc = 1; g_pc = pc_wdata; end
        if (psw_we) begin s_psw = 1; g_psw = psw_wdata; end
        if (sp_we)  begin s_sp = 1; g_sp = sp_wdata; end
        if (halt) s_halt = 1;
        if (syscall) s_sys = 1;
        if (req_ready && busy) s_busy_rdy = 1;
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                if (w_cnt < 4) begin w_addr[w_cnt] = mem_addr; w_data[w_cnt] = mem_wdata; end
                w_cnt++;
                stk[mem_addr[7:2]] = mem_wdata;
            end else begin
                if (r_cnt < 4) r_addr[r_cnt] = mem_addr;
                r_cnt++;
            end
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] k, input logic [3:0] f, input logic [7:0] n,
                       input logic [31:0] pc, input logic [31:0] psw, input logic [31:0] sp,
                       input logic [31:0] intb);
        s_pc = 0; s_psw = 0; s_sp = 0; s_halt = 0; s_sys = 0; w_cnt = 0; r_cnt = 0;
        req_kind = k; req_fault = f; req_intno = n; req_pc = pc;
        psw_in = psw; sp_in = sp; intb_in = intb;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int g = 0; g < 50 && busy; g++) @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic chk_entry(input string tag, input logic [31:0] hpc, input logic [31:0] psw,
                             input logic [31:0] sp, input logic [31:0] rpc);
        chk(s_pc && g_pc == hpc, {tag, " R4 pc"}, g_pc, hpc);
        chk(s_psw && g_psw == (psw & ~MASK), {tag, " R4 psw"}, g_psw, psw & ~MASK);
        chk(s_sp && g_sp == sp - 8, {tag, " R3 sp"}, g_sp, sp - 8);
        chk(w_cnt == 2 && w_addr[0] == sp - 4 && w_data[0] == psw, {tag, " R3 push psw"},
            w_data[0], psw);
        chk(w_addr[1] == sp - 8 && w_data[1] == rpc, {tag, " R3 push pc"}, w_data[1], rpc);
        chk(!s_halt, {tag, " no halt"}, 32'(s_halt), 0);
    endtask

    initial begin
        v_acc = 32'h1000_0D40; v_und = 32'h1000_0DC0; v_prv = 32'h1000_0D00; v_fp = 32'h1000_0E40;
        for (int i = 0; i < 64; i++) stk[i] = 32'hA500_0000 + 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && req_ready && !mem_valid && !pc_we, "R11 reset state",
            {busy, req_ready, mem_valid, pc_we}, 32'h4);

        // R1 / R3 / R4: every fault-flag combination
        for (int f = 1; f < 16; f++) begin
            logic [31:0] exp, psw;
            exp = f[0] ? v_acc : f[1] ? v_und : f[2] ? v_prv : v_fp;
            psw = 32'hFFFF_FFFF ^ (32'(f) * 32'h0101_0101);
            lat = f % 3;
            run(3'd0, 4'(f), 8'd0, 32'h2000_0000 + 32'(f), psw, 32'h80, 0);
            chk(r_cnt >= 1 && g_pc == exp, "R1 priority", g_pc, exp);
            chk_entry("fault", exp, psw, 32'h80, 32'h2000_0000 + 32'(f));
        end

        // R2: each fixed vector empty (zero and placeholder)
        for (int v = 0; v < 4; v++) begin
            for (int z = 0; z < 2; z++) begin
                logic [31:0] e;
                e = (z == 0) ? 32'h0 : 32'h0002_0000;
                v_acc = (v == 0) ? e : 32'h1000_0D40;
                v_und = (v == 1) ? e : 32'h1000_0DC0;
                v_prv = (v == 2) ? e : 32'h1000_0D00;
                v_fp  = (v == 3) ? e : 32'h1000_0E40;
                run(3'd0, 4'(1 << v), 0, 32'h300, 32'h0010_0000, 32'h80, 0);
                chk(s_halt && !s_pc && !s_psw && !s_sp && w_cnt == 0, "R2 unhandled halt",
                    {s_halt, s_pc, s_psw, s_sp, 28'(w_cnt)}, 32'h8000_0000);
            end
        end
        v_acc = 32'h1000_0D40; v_und = 32'h1000_0DC0; v_prv = 32'h1000_0D00; v_fp = 32'h1000_0E40;

        // R5: all vectorable interrupt numbers
        for (int n = 0; n < 255; n++) begin
            logic [31:0] a, psw;
            a = TBL + 32'(4 * n);
            psw = 32'(n) * 32'h0103_0507;
            lat = n % 2;
            run(3'd1, 0, 8'(n), 32'h5000 + 32'(n), psw, 32'hC0, TBL);
            chk(r_cnt == 1 && r_addr[0] == a, "R5 table read", r_addr[0], a);
            chk_entry("swi", 32'h8000_0000 ^ a, psw, 32'hC0, 32'h5000 + 32'(n));
        end

        // R5: break reads the table base
        run(3'd2, 0, 0, 32'h700, 32'hFFFF_FFFF, 32'hF0, TBL);
        chk(r_cnt == 1 && r_addr[0] == TBL, "R5 break read", r_addr[0], TBL);
        chk_entry("brk", 32'h8000_0000 ^ TBL, 32'hFFFF_FFFF, 32'hF0, 32'h700);

        // R6: break with null base
        run(3'd2, 0, 0, 32'h700, 32'h1, 32'hF0, 0);
        chk(s_halt && r_cnt == 0 && w_cnt == 0 && !s_pc, "R6 null base halt",
            32'(r_cnt + w_cnt), 0);

        // R7: interrupt 255
        run(3'd1, 0, 8'd255, 32'h700, 32'h1, 32'hF0, TBL);
        chk(s_sys && !s_halt && r_cnt == 0 && w_cnt == 0 && !s_pc && !s_psw && !s_sp,
            "R7 syscall", 32'(r_cnt + w_cnt), 0);

        // R8: stacked return, restored user mode and supervisor mode
        for (int m = 0; m < 2; m++) begin
            logic [31:0] pp, ep;
            pp = (m == 0) ? 32'h0010_0001 : 32'h0001_0003;
            ep = (m == 0) ? 32'h0012_0001 : 32'h0001_0003;
            stk[16] = 32'h1234_5678; stk[17] = pp;
            lat = m + 1;
            run(3'd3, 0, 0, 32'h900, 32'h0, 32'h40, 0);
            chk(r_cnt == 2 && r_addr[0] == 32'h40 && r_addr[1] == 32'h44, "R8 pop order",
                r_addr[1], 32'h44);
            chk(s_pc && g_pc == 32'h1234_5678, "R8 pc", g_pc, 32'h1234_5678);
            chk(s_psw && g_psw == ep, "R8 psw", g_psw, ep);
            chk(s_sp && g_sp == 32'h48 && w_cnt == 0, "R8 sp", g_sp, 32'h48);
        end

        // R9: returns issued in user mode trap as privileged
        for (int k = 3; k < 5; k++) begin
            run(3'(k), 0, 0, 32'hABC0, 32'h0013_00FF, 32'h80, 0);
            chk(r_cnt >= 1 && r_addr[0] == 32'hFFFF_FFD0, "R9 priv vector", r_addr[0],
                32'hFFFF_FFD0);
            chk_entry("R9", v_prv, 32'h0013_00FF, 32'h80, 32'hABC0);
        end

        // R10: fast return
        bpsw_in = 32'h0010_0005; bpc_in = 32'hCAFE_0000;
        run(3'd4, 0, 0, 32'h900, 32'h0, 32'h40, 0);
        chk(s_pc && g_pc == 32'hCAFE_0000 && s_psw && g_psw == 32'h0010_0005, "R10 fast copy",
            g_psw, 32'h0010_0005);
        chk(!s_sp && r_cnt == 0 && w_cnt == 0, "R10 no stack", 32'(r_cnt + w_cnt), 0);

        // R11: ready never seen while busy; mid-sequence sample
        lat = 2;
        req_kind = 3'd0; req_fault = 4'h1; psw_in = 0; sp_in = 32'h80;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !req_ready, "R11 busy after accept", {busy, req_ready}, 32'h2);
        for (int g = 0; g < 50 && busy; g++) @(negedge clk);
        @(negedge clk);
        chk(!s_busy_rdy, "R11 ready only when idle", 32'(s_busy_rdy), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule